// File: doc/BRIEF.md
# Guarded Software Reset Controller for a Serial Flash Command Port

This block watches the instruction bytes that a host sends to a serial flash device and carries out a software reset. The reset only happens when two opcodes arrive back to back. The first opcode (0x66) arms the controller. The second opcode (0x99) resets the device, but only while the controller is armed. Any other instruction that arrives in between, whether it is well formed or truncated, disarms the controller. The host can send instructions either one bit per clock on IO0 or one nibble per clock on all four IO lines. A static mode input selects between the two.

An accepted reset does three things:
- It returns every volatile register to zero: the write-enable latch, the volatile status bits, the suspend flag, the read parameter byte and the wrap setting.
- It raises a one-cycle abort pulse, which tells the rest of the device to stop any internal operation.
- It starts a lockout of a programmable number of system clock cycles. Busy stays high for the whole lockout, and every instruction that ends during it is rejected with a one-cycle pulse.

The rest of the device loads the volatile registers through an update port. That port is ignored while the reset is in progress. The serial inputs are synchronised into the system clock domain and oversampled, so the serial clock must be several times slower than the system clock.

Top module: `flash_soft_reset`

## Requirements
- R1: A complete instruction 0x66 sets an internal armed flag. A complete 0x99 received while armed starts a reset: busy_o rises and the armed flag clears.
- R2: A 0x99 received while not armed has no effect: no abort, busy_o stays low and the volatile outputs keep their values.
- R3: Any complete instruction other than 0x66 or 0x99 received while armed clears the armed flag, so a following 0x99 does nothing. A fresh 0x66 re-arms the controller.
- R4: With quad_i=0, an opcode is taken from io_i[0] on 8 rising sck_i edges, MSB first. With quad_i=1, it is taken from io_i[3:0] on 2 rising edges, high nibble first.
- R5: An instruction is decoded when cs_ni rises, and only if exactly 8 edges (quad_i=0) or exactly 2 edges (quad_i=1) arrived since cs_ni fell. Any other count is discarded and clears the armed flag.
- R6: An accepted reset clears wel_o, vsr_o, sus_o, rd_param_o and wrap_o to zero, and pulses abort_o high for exactly one cycle.
- R7: busy_o stays high for exactly LOCK_CYC system clock cycles after a reset is accepted. upd_i is ignored while busy_o is high.
- R8: Each instruction that ends while busy_o is high produces exactly one rejected_o pulse. It has no other effect; in particular it does not arm the controller.
- R9: dout_oe_o (the data-out drive enable) is never asserted.
- R10: When busy_o is low, an upd_i pulse loads upd_state_i into the volatile registers, one cycle later. The layout of upd_state_i is:
  - bit 16: wel
  - bits 15:12: vsr
  - bit 11: sus
  - bits 10:3: rd_param
  - bits 2:0: wrap
- R11: Instructions decode correctly whether sck_i idles low or idles high between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| cs_ni | input | 1 | Chip select from the host, active low |
| sck_i | input | 1 | Serial clock from the host |
| io_i | input | 4 | Serial data lines; only IO0 is used when quad_i=0 |
| quad_i | input | 1 | 1 selects nibble-wide framing, 0 selects single-bit framing |
| upd_i | input | 1 | Load strobe for the volatile registers |
| upd_state_i | input | 17 | New volatile register value, in the layout given in R10 |
| wel_o | output | 1 | Write-enable latch |
| vsr_o | output | 4 | Volatile status bits |
| sus_o | output | 1 | Program/erase suspend flag |
| rd_param_o | output | 8 | Read parameter byte |
| wrap_o | output | 3 | Wrap setting |
| busy_o | output | 1 | Reset lockout in progress |
| rejected_o | output | 1 | One-cycle pulse for an instruction that ended during the lockout |
| abort_o | output | 1 | One-cycle pulse that aborts internal operations |
| dout_oe_o | output | 1 | Data-out drive enable, held low |

## Verification
Two events can land in the same cycle: an instruction decode, and the reset lockout. This is provoked in several ways:
- A complete arm opcode is sent right after an accepted reset.
- Every one of the 256 opcodes, in both framings, is placed between an arm and a reset. When the middle opcode is itself 0x99, the trailing 0x99 lands inside the lockout.
- An update pulse is issued in the middle of the lockout.

The bench judges these cases by counting abort and rejected pulses. It also measures the length of the busy window and reads back the volatile outputs once busy drops.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int VSR_W  = 4;
  localparam int RDP_W  = 8;
  localparam int WRAP_W = 3;
  localparam int OP_W   = 8;

  localparam logic [OP_W-1:0] OP_ARM = 8'h66;
  localparam logic [OP_W-1:0] OP_RST = 8'h99;

  typedef struct packed {
    logic              wel;
    logic [VSR_W-1:0]  vsr;
    logic              sus;
    logic [RDP_W-1:0]  rdp;
    logic [WRAP_W-1:0] wrap;
  } vol_t;

  localparam int VOL_W = $bits(vol_t);
endpackage

// File: rtl/fsr_sync.sv
module fsr_sync #(
  parameter int         W       = 1,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q[0] <= RST_VAL;
    else         sr_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sr_q[s] <= RST_VAL;
      else         sr_q[s] <= sr_q[s-1];
    end
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/fsr_frame.sv
module fsr_frame
  import fsr_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cs_n_i,
  input  logic            sck_i,
  input  logic [3:0]      io_i,
  input  logic            quad_i,
  output logic            done_o,
  output logic            ok_o,
  output logic [OP_W-1:0] op_o
);
  localparam int CNT_W = 4;
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] SPI_EDGE = CNT_W'(OP_W);
  localparam logic [CNT_W-1:0] QPI_EDGE = CNT_W'(OP_W / 4);

  logic             cs_q, sck_q;
  logic [CNT_W-1:0] cnt_q;
  logic [OP_W-1:0]  sh_q;
  logic             cs_fall, cs_rise, sck_rise;

  assign cs_fall  = cs_q & ~cs_n_i;
  assign cs_rise  = ~cs_q & cs_n_i;
  assign sck_rise = ~sck_q & sck_i & ~cs_n_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q  <= 1'b1;
      sck_q <= 1'b0;
    end else begin
      cs_q  <= cs_n_i;
      sck_q <= sck_i;
    end
  end

  // cs fall takes priority over a coincident sck edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (cs_fall) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (sck_rise) begin
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      if (quad_i) sh_q <= {sh_q[OP_W-5:0], io_i};
      else        sh_q <= {sh_q[OP_W-2:0], io_i[0]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= 1'b0;
      ok_o   <= 1'b0;
      op_o   <= '0;
    end else begin
      done_o <= cs_rise;
      if (cs_rise) begin
        ok_o <= (cnt_q == (quad_i ? QPI_EDGE : SPI_EDGE));
        op_o <= sh_q;
      end
    end
  end

  a_r5_count_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_fall |=> cnt_q == '0);
  a_r5_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/fsr_seq.sv
module fsr_seq
  import fsr_pkg::*;
#(
  parameter int LOCK_CYC = 3750
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            done_i,
  input  logic            ok_i,
  input  logic [OP_W-1:0] op_i,
  output logic            busy_o,
  output logic            rejected_o,
  output logic            abort_o
);
  localparam int CW = $clog2(LOCK_CYC + 1) + 1;
  localparam logic [CW-1:0] LOAD = CW'(LOCK_CYC - 1);

  logic          armed_q;
  logic [CW-1:0] cnt_q;
  logic          is_arm, is_rst;

  assign is_arm = ok_i && (op_i == OP_ARM);
  assign is_rst = ok_i && (op_i == OP_RST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q    <= 1'b0;
      busy_o     <= 1'b0;
      cnt_q      <= '0;
      rejected_o <= 1'b0;
      abort_o    <= 1'b0;
    end else begin
      rejected_o <= 1'b0;
      abort_o    <= 1'b0;
      if (busy_o) begin
        if (cnt_q == '0) begin
          busy_o  <= 1'b0;
          armed_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
      if (done_i) begin
        if (busy_o) begin
          rejected_o <= 1'b1;
        end else if (is_arm) begin
          armed_q <= 1'b1;
        end else if (is_rst && armed_q) begin
          armed_q <= 1'b0;
          busy_o  <= 1'b1;
          cnt_q   <= LOAD;
          abort_o <= 1'b1;
        end else begin
          armed_q <= 1'b0;
        end
      end
    end
  end

  a_r1_needs_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(armed_q));
  a_r3_disarm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !busy_o && !is_arm) |=> !armed_q);
  a_r8_reject_in_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rejected_o |-> $past(busy_o));
  a_r6_abort_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> $rose(busy_o));
  a_r8_no_arm_in_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !armed_q) |=> !armed_q);
endmodule

// File: rtl/fsr_vol.sv
module fsr_vol
  import fsr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic busy_i,
  input  logic upd_i,
  input  vol_t upd_state_i,
  output vol_t state_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               state_o <= '0;
    else if (clr_i)            state_o <= '0;
    else if (upd_i && !busy_i) state_o <= upd_state_i;
  end

  a_r6_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> state_o == '0);
  a_r7_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !clr_i) |=> $stable(state_o));
  a_r10_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !busy_i && !clr_i) |=> state_o == $past(upd_state_i));
endmodule

// File: rtl/flash_soft_reset.sv
module flash_soft_reset
  import fsr_pkg::*;
#(
  parameter int LOCK_CYC = 3750,
  parameter int SYNC_STG = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sck_i,
  input  logic [3:0]        io_i,
  input  logic              quad_i,
  input  logic              upd_i,
  input  logic [VOL_W-1:0]  upd_state_i,
  output logic              wel_o,
  output logic [VSR_W-1:0]  vsr_o,
  output logic              sus_o,
  output logic [RDP_W-1:0]  rd_param_o,
  output logic [WRAP_W-1:0] wrap_o,
  output logic              busy_o,
  output logic              rejected_o,
  output logic              abort_o,
  output logic              dout_oe_o
);
  logic            cs_s, sck_s;
  logic [3:0]      io_s;
  logic            done, ok;
  logic [OP_W-1:0] op;
  vol_t            st;

  fsr_sync #(.W(6), .STAGES(SYNC_STG), .RST_VAL(6'b100000)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sck_i, io_i}),
    .q_o   ({cs_s, sck_s, io_s})
  );

  fsr_frame i_frame (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cs_n_i(cs_s),
    .sck_i (sck_s),
    .io_i  (io_s),
    .quad_i(quad_i),
    .done_o(done),
    .ok_o  (ok),
    .op_o  (op)
  );

  fsr_seq #(.LOCK_CYC(LOCK_CYC)) i_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .done_i    (done),
    .ok_i      (ok),
    .op_i      (op),
    .busy_o    (busy_o),
    .rejected_o(rejected_o),
    .abort_o   (abort_o)
  );

  fsr_vol i_vol (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (abort_o),
    .busy_i     (busy_o),
    .upd_i      (upd_i),
    .upd_state_i(vol_t'(upd_state_i)),
    .state_o    (st)
  );

  assign wel_o      = st.wel;
  assign vsr_o      = st.vsr;
  assign sus_o      = st.sus;
  assign rd_param_o = st.rdp;
  assign wrap_o     = st.wrap;
  assign dout_oe_o  = 1'b0;

  initial begin
    a_lock_cfg: assert (LOCK_CYC >= 1 && SYNC_STG >= 2);
  end
endmodule

// File: tb/test_flash_soft_reset.sv
module test_flash_soft_reset;
  localparam int LOCK = 200;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        cs_n = 1, sck = 0, quad = 0, upd = 0;
  logic [3:0]  io = 0;
  logic [16:0] upd_state = 0;
  logic        wel, sus, busy, rej, abrt, oe;
  logic [3:0]  vsr;
  logic [7:0]  rdp;
  logic [2:0]  wrap;

  int n_chk = 0, n_bad = 0;
  int n_abort = 0, n_rej = 0, cur_len = 0, last_len = 0;
  bit oe_seen = 0, finished = 0;

  always #4 clk = ~clk;

  flash_soft_reset #(.LOCK_CYC(LOCK)) i_flash_soft_reset (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .io_i(io),
    .quad_i(quad), .upd_i(upd), .upd_state_i(upd_state),
    .wel_o(wel), .vsr_o(vsr), .sus_o(sus), .rd_param_o(rdp), .wrap_o(wrap),
    .busy_o(busy), .rejected_o(rej), .abort_o(abrt), .dout_oe_o(oe)
  );

  always @(posedge clk) begin
    if (abrt) n_abort++;
    if (rej)  n_rej++;
    if (oe)   oe_seen = 1;
    if (busy) cur_len++;
    else if (cur_len != 0) begin
      last_len = cur_len;
      cur_len  = 0;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] op, input int nclk,
                      input logic q, input logic idle_hi);
    quad = q;
    sck  = idle_hi;
    tick(2);
    cs_n = 0;
    tick(4);
    for (int i = 0; i < nclk; i++) begin
      sck = 0;
      if (q) io = (i % 2 == 0) ? op[7:4] : op[3:0];
      else   io = {3'b000, op[7 - (i % 8)]};
      tick(3);
      sck = 1;
      tick(3);
    end
    if (!idle_hi) sck = 0;
    tick(3);
    cs_n = 1;
    io   = 0;
    tick(8);
  endtask

  task automatic wait_idle();
    while (busy) tick(1);
    tick(4);
  endtask

  task automatic load(input logic [16:0] v);
    upd_state = v;
    upd = 1;
    tick(1);
    upd = 0;
    tick(2);
  endtask

  task automatic check_state(input string req, input logic [16:0] v);
    check({req, " wel"},  int'(wel),  int'(v[16]));
    check({req, " vsr"},  int'(vsr),  int'(v[15:12]));
    check({req, " sus"},  int'(sus),  int'(v[11]));
    check({req, " rdp"},  int'(rdp),  int'(v[10:3]));
    check({req, " wrap"}, int'(wrap), int'(v[2:0]));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int base, rbase;
    logic [16:0] pat;
    tick(3);
    rst_n = 1;
    tick(3);
    // reset state
    check_state("R6 por", 17'h0);
    check("R7 por busy", int'(busy), 0);

    // R10 load
    pat = 17'h1ABCD;
    load(pat);
    check_state("R10", pat);

    // R2 lone reset opcode
    base = n_abort;
    send(8'h99, 8, 0, 0);
    check("R2 abort", n_abort - base, 0);
    check("R2 busy", int'(busy), 0);
    check_state("R2", pat);

    // R1 R6 R7: reset clears, busy length, update ignored in lockout
    base = n_abort;
    send(8'h66, 8, 0, 0);
    send(8'h99, 8, 0, 1);
    check("R1 busy", int'(busy), 1);
    check("R6 abort", n_abort - base, 1);
    tick(10);
    load(17'h1FFFF);
    wait_idle();
    check_state("R6 R7", 17'h0);
    check("R7 length", last_len, LOCK);

    // R8: arm during lockout is rejected and has no effect
    load(pat);
    send(8'h66, 2, 1, 0);
    send(8'h99, 2, 1, 1);
    rbase = n_rej;
    base  = n_abort;
    send(8'h66, 8, 0, 0);
    check("R8 busy still", int'(busy), 1);
    wait_idle();
    check("R8 rejected", n_rej - rbase, 1);
    send(8'h99, 8, 0, 0);
    check("R8 no arm", n_abort - base, 0);
    check_state("R8 R4", 17'h0);

    // R3 R4 R11: every opcode between arm and reset, both framings
    for (int qm = 0; qm < 2; qm++) begin
      for (int op = 0; op < 256; op++) begin
        int nb;
        nb = (qm == 1) ? 2 : 8;
        base = n_abort;
        send(8'h66, nb, logic'(qm), logic'(op[0]));
        send(8'(op), nb, logic'(qm), logic'(op[1]));
        send(8'h99, nb, logic'(qm), logic'(op[2]));
        wait_idle();
        check("R3 R4 R11 sweep", n_abort - base,
              (op == 'h66 || op == 'h99) ? 1 : 0);
      end
    end

    // R5: arm frames with every edge count
    for (int n = 0; n < 13; n++) begin
      base = n_abort;
      send(8'h66, n, 0, 0);
      send(8'h99, 8, 0, 0);
      wait_idle();
      check("R5 spi count", n_abort - base, (n == 8) ? 1 : 0);
    end
    for (int n = 0; n < 6; n++) begin
      base = n_abort;
      send(8'h66, n, 1, 1);
      send(8'h99, 2, 1, 1);
      wait_idle();
      check("R5 qpi count", n_abort - base, (n == 2) ? 1 : 0);
    end

    // R5 R3: truncated frame disarms
    base = n_abort;
    send(8'h66, 8, 0, 0);
    send(8'h99, 7, 0, 0);
    send(8'h99, 8, 0, 0);
    wait_idle();
    check("R5 truncated disarm", n_abort - base, 0);

    check("R9 oe", int'(oe_seen), 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule